// File: doc/BRIEF.md
# Spindle-Following Step Generator with Period Interpolation

This block drives a stepper motor that follows a rotating spindle at a programmable gear ratio. Its only view of the spindle is a single pulse line from a coarse encoder. Each rising edge on that line is stamped with the value of a slow, free-running tick counter. The difference between two stamps gives the time the last encoder slot took. That time is taken as the forecast for the slot now starting. It is split by a right shift into 2^SUB_LOG2 equal slices, and a synthetic pulse is emitted at each slice boundary. With the defaults, a 512-slot encoder therefore acts as an 8192-slot one.

Every real edge and every synthetic pulse counts as one sub-pulse. Each sub-pulse adds the ratio numerator to a remainder accumulator. When the accumulator reaches the denominator, one motor step is issued and the accumulator drops by the denominator. Steps are therefore spread evenly and land between real edges as well as on them. A step is a clean high pulse of programmable width on `stepOut`. `dirOut` is settled before the step rises. If the spindle stops sending edges, a timeout invalidates the measured period and interpolation stays off until two fresh edges have been seen.

`encIn` is expected to be synchronous to `clk`. The ratio, step width and direction request are plain inputs that the surrounding logic holds steady.

Top module: `spindleStepGen`

## Requirements
- R1: After reset `stepOut` and `dirOut` are low, and no step is issued until an encoder edge arrives.
- R2: A real edge is a cycle in which `encIn` is high after being low in the previous cycle. Every real edge is a sub-pulse, whether or not the period measurement is valid.
- R3: The tick counter advances once every TICK_DIV clock cycles. The period is the difference of two successive edge stamps taken modulo 2^CNT_W, so a counter wrap between the edges still yields the true period.
- R4: The slice length is the last measured period shifted right by SUB_LOG2, with 1 used when the shift gives 0. Synthetic pulse k (k = 1 .. 2^SUB_LOG2-1) is due k slice lengths after the edge is captured.
- R5: A real edge restarts the slice timer and the slice index. Synthetic pulses that would fall on or after the next real edge are dropped. A late edge leaves the sequence halted after the last synthetic pulse until the edge arrives.
- R6: On each sub-pulse the numerator is added to the remainder. When the sum is at least the denominator, one step is issued and the denominator is subtracted (requires 1 <= ratioDen and ratioNum <= ratioDen). For example, 1/3 gives skip, skip, step.
- R7: If TIMEOUT_TICKS ticks pass without a real edge, the period becomes invalid and synthetic pulses cease.
- R8: A step launched from an idle pulse generator rises on `stepOut` two cycles after its sub-pulse cycle. It stays high for stepLen cycles, or 1 cycle when stepLen is 0. At least two low cycles separate pulses, and steps requested while a pulse is running are queued, not lost.
- R9: `dirOut` takes the value of `dirReq` when a step is launched, one cycle before the step rises. It never changes while `stepOut` is high or in the cycle of its rising edge.
- R10: Synthetic pulses start only after two real edges have been captured since reset or since a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| encIn | input | 1 | Encoder pulse line, synchronous to clk |
| dirReq | input | 1 | Wanted motor direction, latched at each step launch |
| ratioNum | input | RATIO_W | Ratio numerator added per sub-pulse |
| ratioDen | input | RATIO_W | Ratio denominator, sub-pulses per step scale |
| stepLen | input | LEN_W | Step pulse high time in clock cycles |
| stepOut | output | 1 | Step pulse to the motor driver |
| dirOut | output | 1 | Direction to the motor driver |

## Verification
The real edge is captured on the clock edge after `encIn` rises. Synthetic pulse k is captured k·subLen ticks later. A step shows up on `stepOut` two cycles after the capture of its sub-pulse, or two cycles after the previous pulse falls if that is later. The stimulus drives each edge at a falling clock edge and notes the cycle number. From the same numbers it forecasts every sub-pulse, runs the ratio arithmetic, and queues the exact cycle, direction and width of each expected step. A monitor that samples at falling edges compares the actual rise cycle and the high time against the head of that queue. A missing, extra or shifted step therefore shows up even inside a long run of queued pulses.

// File: rtl/stepInterpPkg.sv
package stepInterpPkg;

  // strobes from the control section to the datapath
  typedef struct packed {
    logic tickEn;      // capture counter advances this cycle
    logic realEdge;    // encoder rising edge seen this cycle
    logic takePeriod;  // a previous stamp exists: update the period
    logic subPulse;    // real edge or synthetic pulse
  } ctrlStrobesT;

  typedef enum logic [1:0] {
    PG_IDLE  = 2'd0,
    PG_SETUP = 2'd1,
    PG_HIGH  = 2'd2
  } pulseStateT;

endpackage

// File: rtl/stepInterpCtrl.sv
module stepInterpCtrl
  import stepInterpPkg::*;
#(
  parameter int TICK_DIV      = 100,
  parameter int SUB_LOG2      = 4,
  parameter int TIMEOUT_TICKS = 50000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        encIn,
  input  logic        subDone,
  output ctrlStrobesT strobes,
  output logic        periodValid
);

  localparam int SUB_N  = 1 << SUB_LOG2;
  localparam int IDX_W  = SUB_LOG2;
  localparam int TO_W   = $clog2(TIMEOUT_TICKS + 1);
  localparam int PRES_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic             tickEn;
  logic             encPrev;
  logic             realEdge;
  logic [1:0]       edgeSeen;
  logic [TO_W-1:0]  idleTicks;
  logic [IDX_W-1:0] subIdx;
  logic             idleHit;
  logic             synthFire;

  // tick prescaler: variant picked by the division ratio
  if (TICK_DIV > 1) begin : gPres
    logic [PRES_W-1:0] presCnt;
    always_ff @(posedge clk) begin
      if (!rstN)                              presCnt <= '0;
      else if (presCnt == PRES_W'(TICK_DIV-1)) presCnt <= '0;
      else                                    presCnt <= presCnt + 1'b1;
    end
    assign tickEn = (presCnt == PRES_W'(TICK_DIV-1));
  end else begin : gNoPres
    assign tickEn = 1'b1;
  end

  assign realEdge    = encIn & ~encPrev;
  assign periodValid = (edgeSeen == 2'd2);
  assign idleHit     = tickEn && (edgeSeen != 2'd0) && !realEdge &&
                       (idleTicks == TO_W'(TIMEOUT_TICKS-1));
  assign synthFire   = periodValid && tickEn && subDone && !realEdge &&
                       (subIdx != IDX_W'(SUB_N-1));

  assign strobes.tickEn     = tickEn;
  assign strobes.realEdge   = realEdge;
  assign strobes.takePeriod = realEdge && (edgeSeen != 2'd0);
  assign strobes.subPulse   = realEdge || synthFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encPrev   <= 1'b0;
      edgeSeen  <= 2'd0;
      idleTicks <= '0;
      subIdx    <= '0;
    end else begin
      encPrev <= encIn;
      if (realEdge) begin
        edgeSeen  <= (edgeSeen == 2'd2) ? 2'd2 : edgeSeen + 2'd1;
        idleTicks <= '0;
        subIdx    <= '0;
      end else begin
        if (idleHit)
          edgeSeen <= 2'd0;
        else if (tickEn && edgeSeen != 2'd0)
          idleTicks <= idleTicks + 1'b1;
        if (synthFire)
          subIdx <= subIdx + 1'b1;
      end
    end
  end

  a_r7_timeout_invalidates: assert property (@(posedge clk) disable iff (!rstN)
    idleHit |=> !periodValid);

  a_r5_edge_restarts_index: assert property (@(posedge clk) disable iff (!rstN)
    realEdge |=> (subIdx == '0));

  a_r10_first_edge_not_valid: assert property (@(posedge clk) disable iff (!rstN)
    (realEdge && edgeSeen == 2'd0) |=> !periodValid);

endmodule

// File: rtl/stepInterpDatapath.sv
module stepInterpDatapath
  import stepInterpPkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SUB_LOG2 = 4,
  parameter int RATIO_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobesT        strobes,
  input  logic               periodValid,
  input  logic [RATIO_W-1:0] ratioNum,
  input  logic [RATIO_W-1:0] ratioDen,
  output logic               subDone,
  output logic               stepReq
);

  logic [CNT_W-1:0]   capCnt;
  logic [CNT_W-1:0]   capLast;
  logic [CNT_W-1:0]   period;
  logic [CNT_W-1:0]   subTimer;
  logic [CNT_W-1:0]   subLenRaw;
  logic [CNT_W-1:0]   subLen;
  logic [CNT_W:0]     timerNext;
  logic [RATIO_W-1:0] acc;
  logic [RATIO_W:0]   accSum;
  logic               stepHit;

  // slice length by shift only; never below one tick
  assign subLenRaw = period >> SUB_LOG2;
  assign subLen    = (subLenRaw == '0) ? CNT_W'(1) : subLenRaw;
  assign timerNext = {1'b0, subTimer} + 1'b1;
  assign subDone   = (timerNext >= {1'b0, subLen});

  assign accSum  = {1'b0, acc} + {1'b0, ratioNum};
  assign stepHit = (accSum >= {1'b0, ratioDen});
  assign stepReq = strobes.subPulse && stepHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capCnt   <= '0;
      capLast  <= '0;
      period   <= '0;
      subTimer <= '0;
      acc      <= '0;
    end else begin
      if (strobes.tickEn)
        capCnt <= capCnt + 1'b1;
      if (strobes.realEdge)
        capLast <= capCnt;
      if (strobes.takePeriod)
        period <= capCnt - capLast;   // modulo 2^CNT_W
      if (strobes.realEdge)
        subTimer <= '0;
      else if (strobes.tickEn && periodValid)
        subTimer <= subDone ? '0 : subTimer + 1'b1;
      if (strobes.subPulse)
        acc <= stepHit ? RATIO_W'(accSum - {1'b0, ratioDen}) : accSum[RATIO_W-1:0];
    end
  end

  a_r3_period_wraps: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takePeriod |=> (CNT_W'($past(capLast) + period) == capLast));

  a_r6_remainder_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.subPulse && acc < ratioDen && ratioNum <= ratioDen)
      |=> (acc < $past(ratioDen)));

endmodule

// File: rtl/stepPulseGen.sv
module stepPulseGen
  import stepInterpPkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepReq,
  input  logic             dirReq,
  input  logic [LEN_W-1:0] stepLen,
  output logic             stepOut,
  output logic             dirOut
);

  pulseStateT        state;
  logic [PEND_W-1:0] pend;
  logic [LEN_W-1:0]  hiCnt;
  logic [LEN_W-1:0]  lenEff;
  logic              start;

  assign lenEff = (stepLen == '0) ? LEN_W'(1) : stepLen;
  assign start  = (state == PG_IDLE) && (stepReq || pend != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= PG_IDLE;
      pend    <= '0;
      hiCnt   <= '0;
      stepOut <= 1'b0;
      dirOut  <= 1'b0;
    end else begin
      pend <= pend + PEND_W'(stepReq) - PEND_W'(start);
      case (state)
        PG_IDLE: begin
          if (start) begin
            dirOut <= dirReq;
            state  <= PG_SETUP;
          end
        end
        PG_SETUP: begin
          stepOut <= 1'b1;
          hiCnt   <= lenEff - 1'b1;
          state   <= PG_HIGH;
        end
        PG_HIGH: begin
          if (hiCnt == '0) begin
            stepOut <= 1'b0;
            state   <= PG_IDLE;
          end else begin
            hiCnt <= hiCnt - 1'b1;
          end
        end
        default: state <= PG_IDLE;
      endcase
    end
  end

  a_r9_dir_settled_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stepOut) |-> $stable(dirOut));

  a_r9_dir_held_while_high: assert property (@(posedge clk) disable iff (!rstN)
    stepOut |-> $stable(dirOut));

  a_r8_low_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stepOut) |=> !stepOut);

  a_r8_queue_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq && !start) |-> (pend != '1));

endmodule

// File: rtl/spindleStepGen.sv
module spindleStepGen
  import stepInterpPkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int TICK_DIV      = 100,
  parameter int SUB_LOG2      = 4,
  parameter int RATIO_W       = 12,
  parameter int LEN_W         = 8,
  parameter int PEND_W        = 4,
  parameter int TIMEOUT_TICKS = 50000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               encIn,
  input  logic               dirReq,
  input  logic [RATIO_W-1:0] ratioNum,
  input  logic [RATIO_W-1:0] ratioDen,
  input  logic [LEN_W-1:0]   stepLen,
  output logic               stepOut,
  output logic               dirOut
);

  ctrlStrobesT strobes;
  logic        periodValid;
  logic        subDone;
  logic        stepReq;

  stepInterpCtrl #(
    .TICK_DIV      (TICK_DIV),
    .SUB_LOG2      (SUB_LOG2),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .encIn       (encIn),
    .subDone     (subDone),
    .strobes     (strobes),
    .periodValid (periodValid)
  );

  stepInterpDatapath #(
    .CNT_W    (CNT_W),
    .SUB_LOG2 (SUB_LOG2),
    .RATIO_W  (RATIO_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .periodValid (periodValid),
    .ratioNum    (ratioNum),
    .ratioDen    (ratioDen),
    .subDone     (subDone),
    .stepReq     (stepReq)
  );

  stepPulseGen #(
    .LEN_W  (LEN_W),
    .PEND_W (PEND_W)
  ) pulse_i (
    .clk     (clk),
    .rstN    (rstN),
    .stepReq (stepReq),
    .dirReq  (dirReq),
    .stepLen (stepLen),
    .stepOut (stepOut),
    .dirOut  (dirOut)
  );

endmodule

// File: tb/spindleStepGen_tb_top.sv
module spindleStepGen_tb_top;

  localparam int CNT_W         = 10;
  localparam int TICK_DIV      = 1;
  localparam int SUB_LOG2      = 4;
  localparam int RATIO_W       = 8;
  localparam int LEN_W         = 8;
  localparam int PEND_W        = 4;
  localparam int TIMEOUT_TICKS = 1000;
  localparam int SUB_N         = 1 << SUB_LOG2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               encIn = 1'b0;
  logic               dirReq = 1'b1;
  logic [RATIO_W-1:0] ratioNum = 8'd1;
  logic [RATIO_W-1:0] ratioDen = 8'd3;
  logic [LEN_W-1:0]   stepLen = 8'd3;
  logic               stepOut;
  logic               dirOut;

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  spindleStepGen #(
    .CNT_W(CNT_W), .TICK_DIV(TICK_DIV), .SUB_LOG2(SUB_LOG2), .RATIO_W(RATIO_W),
    .LEN_W(LEN_W), .PEND_W(PEND_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .encIn(encIn), .dirReq(dirReq),
    .ratioNum(ratioNum), .ratioDen(ratioDen), .stepLen(stepLen),
    .stepOut(stepOut), .dirOut(dirOut)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string phase = "R1 reset";

  typedef struct { int rise; bit dir; int len; } expT;
  expT expQ[$];

  // reference model state
  int mAcc = 0, mSeen = 0, mLastEdge = -1, mL = 1;
  int mLastRise = -100, mLastLen = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one sub-pulse captured at the clock edge following cycle t
  task automatic modelPulse(int t);
    expT item;
    int  len;
    mAcc += int'(ratioNum);
    if (mAcc >= int'(ratioDen)) begin
      mAcc -= int'(ratioDen);
      len = (stepLen == 0) ? 1 : int'(stepLen);
      item.rise = (t + 2 > mLastRise + mLastLen + 2) ? t + 2 : mLastRise + mLastLen + 2;
      item.dir  = dirReq;
      item.len  = len;
      mLastRise = item.rise;
      mLastLen  = len;
      expQ.push_back(item);
    end
  endtask

  // drive one encoder edge now; the following edge comes gap cycles later
  task automatic runEdge(int gap);
    int e;
    int per;
    @(negedge clk);
    e = cyc;
    encIn = 1'b1;
    if (mLastEdge >= 0 && e - mLastEdge > TIMEOUT_TICKS) mSeen = 0;
    if (mSeen >= 1) begin
      per = (e - mLastEdge) % (1 << CNT_W);
      mL = per >> SUB_LOG2;
      if (mL == 0) mL = 1;
    end
    if (mSeen < 2) mSeen++;
    modelPulse(e);
    if (mSeen == 2)
      for (int k = 1; k < SUB_N; k++)
        if (k * mL < gap && k * mL <= TIMEOUT_TICKS) modelPulse(e + k * mL);
    mLastEdge = e;
    @(negedge clk);
    encIn = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    bit  prev = 1'b0;
    bit  have = 1'b0;
    int  riseAt = 0;
    expT cur;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        prev = 1'b0;
        continue;
      end
      if (stepOut && !prev) begin
        riseAt = cyc;
        if (expQ.size() == 0) begin
          check(1'b0, {phase, " R6 unexpected step"}, cyc, -1);
        end else begin
          cur = expQ.pop_front();
          have = 1'b1;
          check(cyc == cur.rise, {phase, " R8 step rise cycle"}, cyc, cur.rise);
          check(dirOut == cur.dir, {phase, " R9 direction at rise"}, int'(dirOut), int'(cur.dir));
        end
      end
      if (!stepOut && prev && have) begin
        check(cyc - riseAt == cur.len, {phase, " R8 pulse width"}, cyc - riseAt, cur.len);
        have = 1'b0;
      end
      prev = stepOut;
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(stepOut == 1'b0, "R1 stepOut low in reset", int'(stepOut), 0);
    check(dirOut == 1'b0, "R1 dirOut low in reset", int'(dirOut), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(stepOut == 1'b0, "R1 no step before an edge", int'(stepOut), 0);
    check(dirOut == 1'b0, "R1 dirOut idle before an edge", int'(dirOut), 0);

    // startup: first edge only counts itself; R10 interpolation after second
    phase = "R2 R10 startup";
    runEdge(200);
    runEdge(160);            // slice 12, early next edge drops the tail (R5)
    phase = "R4 steady";
    runEdge(160);
    runEdge(160);
    runEdge(160);
    phase = "R5 early edge";
    runEdge(100);
    phase = "R5 late edge";
    runEdge(250);            // slice 6: halts after 15th, waits
    phase = "R3 wrap R4 prediction";
    runEdge(400);            // tick counter wraps every 1024 cycles here

    phase = "R9 direction and ratio";
    dirReq   = 1'b0;
    ratioNum = 8'd2;
    ratioDen = 8'd5;
    stepLen  = 8'd1;
    runEdge(160);
    runEdge(600);

    phase = "R8 backlog";
    ratioNum = 8'd1;
    ratioDen = 8'd1;
    stepLen  = 8'd9;
    runEdge(160);
    runEdge(160);
    runEdge(800);

    phase = "R7 timeout";
    ratioNum = 8'd1;
    ratioDen = 8'd3;
    stepLen  = 8'd3;
    dirReq   = 1'b1;
    runEdge(1500);           // timeout fires inside this gap
    runEdge(180);            // first edge after stop: no synthetic pulses
    runEdge(200);            // second edge: interpolation resumes

    phase = "R4 short period";
    runEdge(12);
    runEdge(12);
    runEdge(300);            // slice clamps to one tick

    repeat (500) @(negedge clk);
    check(expQ.size() == 0, "R6 all expected steps issued", expQ.size(), 0);
    check(stepOut == 1'b0, "R8 idle after drain", int'(stepOut), 0);
    finishRun();
  end

endmodule